// File: doc/BRIEF.md
# Multi-Channel Byte Mover with Bus Throttling

This block copies data one byte at a time between any two locations in a 16-bit address space. It does the work for peripherals, so the processor does not have to take an interrupt for every byte. Software gives each channel a source address, a destination address, a byte count of up to 256, and a control byte. A channel then moves bytes for as long as its peripheral request is high, until the count runs out. Each byte uses two bus clocks: a read from the source, then a write to the destination in the next clock. The processor's own state is left alone; the block only takes bus cycles from it.

Several channels can ask at once. The lowest-numbered ready channel wins. A global setting limits how much of the bus the block may use, in quarters. Time is split into an 8-clock frame of four 2-clock slots, and a byte may only start in a slot the setting allows. A global bit decides whether transfers may go on while the processor sits in low-power wait. When a block ends, the channel raises its done flag and turns itself off. If that channel's interrupt enable is set, the shared interrupt line goes high.

Top module: `dma_mover`

## Requirements
- R1: A byte transfer is one clock with `bus_rd` high and `bus_addr` equal to the channel's source address. It is followed by exactly one clock with `bus_we` high, `bus_addr` equal to the destination address, and `bus_wdata` equal to the byte read. `bus_rd` and `bus_we` are never high together.
- R2: After each byte, the source address steps by one if control bit 1 is set, and the destination address steps by one if control bit 2 is set. The two are independent, and both wrap at 16 bits.
- R3: The count register (offset 4) goes down by one per byte and reads 0 when the block ends. Writing 0 to it starts a block of 256 bytes.
- R4: When the last byte is written, status bit 0 (done) becomes 1 and control bit 0 (enable) becomes 0. No more bus cycles happen for that channel while its request stays high. Writing a 1 to status bit 0 clears done.
- R5: `irq` is high exactly when some channel has done set and its control bit 3 (interrupt enable) set.
- R6: When several enabled channels have their requests high, bytes are moved for the lowest-numbered one first.
- R7: Bits [1:0] of the global register choose the bus share: 0=25%, 1=50%, 2=75%, 3=100%. A frame is 8 clocks, counted from reset, and holds four 2-clock slots. A read may start only on an even clock, in slot 0 for 25%, slots 0 and 2 for 50%, slots 0 to 2 for 75%, and any slot for 100%. With a steady request, the gap between reads is 8, 4 or 2 clocks for 25%, 50% and 100%. For 75%, any three gaps in a row add up to 8 clocks.
- R8: While `wait_mode` is high and global bit 2 is 0, no new byte starts. If global bit 2 is 1, transfers go on during wait.
- R9: A byte starts only if `bus_grant` was high in the clock before its read. `bus_req` is high whenever an enabled channel is requesting or a byte is in progress.
- R10: After reset, all registers read 0, and `irq`, `bus_req`, `bus_rd` and `bus_we` are 0.
- R11: The registers of channel c sit at `reg_addr` = 8*c + offset. The offsets are: 0 source low, 1 source high, 2 destination low, 3 destination high, 4 count, 5 control (bits 3:0), 6 status. The global register is at address 56. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (channel in bits 5:3, offset in bits 2:0) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| dma_req | input | NCH | Per-channel peripheral service request |
| wait_mode | input | 1 | Processor is in low-power wait |
| bus_req | output | 1 | Request for bus mastership |
| bus_grant | input | 1 | Bus granted to this block |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_we | output | 1 | Write cycle strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid during the read cycle |
| irq | output | 1 | Block-complete interrupt |

## Verification
A wrong address counter shows up as wrong bytes in destination memory. A wrong byte count shows up as the wrong number of read strobes. Both are visible as soon as the block ends, and the count register can also be read between bytes. A fault in the throttle frame or in the launch decision shows up on the very next read strobe, as a read on an odd clock or in a forbidden slot, or as a gap between reads that does not match the chosen share. A stale done or enable bit shows up at once on `irq`, or as extra bus cycles after the block ends while the request is still high.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int MAX_CH  = 7;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;

    localparam logic [2:0] OFF_SRC_LO = 3'd0;
    localparam logic [2:0] OFF_SRC_HI = 3'd1;
    localparam logic [2:0] OFF_DST_LO = 3'd2;
    localparam logic [2:0] OFF_DST_HI = 3'd3;
    localparam logic [2:0] OFF_COUNT  = 3'd4;
    localparam logic [2:0] OFF_CTRL   = 3'd5;
    localparam logic [2:0] OFF_STAT   = 3'd6;
    localparam logic [2:0] GLOBAL_SEL = 3'd7;

    // control byte bits [3:0]
    typedef struct packed {
        logic irq_en;
        logic dst_inc;
        logic src_inc;
        logic en;
    } ch_ctrl_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_state_t;

    // slots of the 8-clock frame in which a byte may start
    function automatic logic [3:0] slot_mask(input logic [1:0] share);
        case (share)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0101;
            2'd2:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [7:0]        cnt,
    output ch_ctrl_t          ctrl,
    output logic              done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            ctrl <= '0;
            done <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_off)
                    OFF_SRC_LO: src[7:0]  <= wr_data;
                    OFF_SRC_HI: src[15:8] <= wr_data;
                    OFF_DST_LO: dst[7:0]  <= wr_data;
                    OFF_DST_HI: dst[15:8] <= wr_data;
                    OFF_COUNT:  cnt       <= wr_data;
                    OFF_CTRL:   ctrl      <= ch_ctrl_t'(wr_data[3:0]);
                    OFF_STAT:   if (wr_data[0]) done <= 1'b0;
                    default: ;
                endcase
            end
            // engine update has the last word over a same-cycle write
            if (step) begin
                if (ctrl.src_inc) src <= src + ADDR_W'(1);
                if (ctrl.dst_inc) dst <= dst + ADDR_W'(1);
                cnt <= cnt - 8'd1;
                if (cnt == 8'd1) begin
                    done    <= 1'b1;
                    ctrl.en <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pending,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |pending;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/dma_throttle.sv
module dma_throttle
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] share,
    output logic       launch_ok
);

    logic [2:0] tick;
    logic [1:0] next_slot;
    logic [3:0] mask;

    always_ff @(posedge clk) begin
        if (rst) tick <= '0;
        else     tick <= tick + 3'd1;
    end

    // decision is taken on the odd clock just before a slot opens
    assign next_slot = tick[2:1] + 2'd1;
    assign mask      = slot_mask(share);
    assign launch_ok = tick[0] && mask[next_slot];

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [IW-1:0]     go_ch,
    input  logic [DATA_W-1:0] rdata,
    output eng_state_t        state,
    output logic [IW-1:0]     cur_ch,
    output logic [DATA_W-1:0] data_q,
    output logic              step
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            cur_ch <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (go) begin
                        state  <= ENG_READ;
                        cur_ch <= go_ch;
                    end
                end
                ENG_READ: begin
                    data_q <= rdata;
                    state  <= ENG_WRITE;
                end
                ENG_WRITE: begin
                    if (go) begin
                        state  <= ENG_READ;
                        cur_ch <= go_ch;
                    end else begin
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign step = (state == ENG_WRITE);

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NCH-1:0]    dma_req,
    input  logic              wait_mode,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic [15:0]       bus_addr,
    output logic              bus_rd,
    output logic              bus_we,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              irq
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [1:0]        bw_sel;
    logic              run_wait;
    logic [ADDR_W-1:0] src_a [NCH];
    logic [ADDR_W-1:0] dst_a [NCH];
    logic [7:0]        cnt_a [NCH];
    ch_ctrl_t          ctrl_a [NCH];
    logic [NCH-1:0]    done_v;
    logic [NCH-1:0]    pending;
    logic              any_pend;
    logic [IW-1:0]     win_ch;
    logic              launch_ok;
    logic              go;
    eng_state_t        state;
    logic [IW-1:0]     cur_ch;
    logic [DATA_W-1:0] data_q;
    logic              step;

    wire [2:0] sel = reg_addr[5:3];
    wire [2:0] off = reg_addr[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bw_sel   <= 2'd0;
            run_wait <= 1'b0;
        end else if (reg_wr && sel == GLOBAL_SEL && off == 3'd0) begin
            bw_sel   <= reg_wdata[1:0];
            run_wait <= reg_wdata[2];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_chan_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (reg_wr && sel == 3'(c)),
            .wr_off  (off),
            .wr_data (reg_wdata),
            .step    (step && cur_ch == IW'(c)),
            .src     (src_a[c]),
            .dst     (dst_a[c]),
            .cnt     (cnt_a[c]),
            .ctrl    (ctrl_a[c]),
            .done    (done_v[c])
        );
    end

    // a channel finishing its last byte this cycle must not relaunch
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            pending[c] = ctrl_a[c].en && dma_req[c]
                       && !(step && cur_ch == IW'(c) && cnt_a[c] == 8'd1);
        end
    end

    dma_arbiter #(.N(NCH), .IW(IW)) u_arb (
        .pending (pending),
        .any     (any_pend),
        .idx     (win_ch)
    );

    dma_throttle u_thr (
        .clk       (clk),
        .rst       (rst),
        .share     (bw_sel),
        .launch_ok (launch_ok)
    );

    assign go = any_pend && launch_ok && bus_grant
             && !(wait_mode && !run_wait) && (state != ENG_READ);

    dma_engine #(.IW(IW)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .go_ch  (win_ch),
        .rdata  (bus_rdata),
        .state  (state),
        .cur_ch (cur_ch),
        .data_q (data_q),
        .step   (step)
    );

    assign bus_req   = any_pend || (state != ENG_IDLE);
    assign bus_rd    = (state == ENG_READ);
    assign bus_we    = (state == ENG_WRITE);
    assign bus_wdata = data_q;

    always_comb begin
        case (state)
            ENG_READ:  bus_addr = src_a[cur_ch];
            ENG_WRITE: bus_addr = dst_a[cur_ch];
            default:   bus_addr = '0;
        endcase
    end

    always_comb begin
        irq = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (done_v[c] && ctrl_a[c].irq_en) irq = 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel == GLOBAL_SEL) begin
            if (off == 3'd0) reg_rdata = {5'd0, run_wait, bw_sel};
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (sel == 3'(c)) begin
                    case (off)
                        OFF_SRC_LO: reg_rdata = src_a[c][7:0];
                        OFF_SRC_HI: reg_rdata = src_a[c][15:8];
                        OFF_DST_LO: reg_rdata = dst_a[c][7:0];
                        OFF_DST_HI: reg_rdata = dst_a[c][15:8];
                        OFF_COUNT:  reg_rdata = cnt_a[c];
                        OFF_CTRL:   reg_rdata = {4'd0, ctrl_a[c]};
                        OFF_STAT:   reg_rdata = {7'd0, done_v[c]};
                        default:    reg_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk
    import dma_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_rd,
    input logic       bus_we,
    input logic       bus_grant,
    input logic       wait_mode,
    input logic       run_wait,
    input logic [1:0] bw_sel
);

    logic [2:0] frame;
    logic [3:0] prev_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame     <= '0;
            prev_mask <= '0;
        end else begin
            frame     <= frame + 3'd1;
            prev_mask <= slot_mask(bw_sel);
        end
    end

    a_r1_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_we);

    a_r1_write_needs_read: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> $past(bus_rd));

    a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_we));

    a_r7_slot_allowed: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (!frame[0] && prev_mask[frame[2:1]]));

    a_r9_granted: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> $past(bus_grant));

    a_r8_wait_gate: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> $past(run_wait || !wait_mode));

endmodule

bind dma_mover dma_mover_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_we    (bus_we),
    .bus_grant (bus_grant),
    .wait_mode (wait_mode),
    .run_wait  (run_wait),
    .bw_sel    (bw_sel)
);

// File: tb/dma_mover_test.sv
`timescale 1ns/1ps
module dma_mover_test;

    localparam int NCH = 3;

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [7:0]  cnt;
        logic [3:0]  ctrl;
        logic [1:0]  bw;
    } vec_t;

    // ctrl: bit0 enable, bit1 src step, bit2 dst step, bit3 irq enable
    localparam vec_t VECS [8] = '{
        '{16'h0010, 16'h0200, 8'd4, 4'hF, 2'd3},
        '{16'h0020, 16'h0210, 8'd5, 4'hF, 2'd0},
        '{16'h0030, 16'h0220, 8'd6, 4'hF, 2'd1},
        '{16'h0040, 16'h0230, 8'd7, 4'h7, 2'd2},
        '{16'h0000, 16'h0100, 8'd0, 4'hF, 2'd3},
        '{16'h0050, 16'h0240, 8'd3, 4'h5, 2'd3},
        '{16'h0060, 16'h0250, 8'd3, 4'h3, 2'd3},
        '{16'hFFFE, 16'h0260, 8'd4, 4'h7, 2'd3}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_wr = 1'b0;
    logic [5:0]     reg_addr = '0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] dma_req = '0;
    logic           wait_mode = 1'b0;
    logic           bus_req;
    logic           grant_en = 1'b1;
    logic [15:0]    bus_addr;
    logic           bus_rd;
    logic           bus_we;
    logic [7:0]     bus_wdata;
    logic [7:0]     bus_rdata;
    logic           irq;

    logic [7:0] mem  [1024];
    logic [7:0] orig [1024];
    logic [7:0] expm [1024];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_n = 0;
    int gap_bad = 0;
    int mon_bw = -1;
    int last_t = 0;
    int g1 = 0;
    int g2 = 0;
    logic [15:0] rd_log [16];

    always #4 clk = ~clk;

    dma_mover #(.NCH(NCH)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_req   (dma_req),
        .wait_mode (wait_mode),
        .bus_req   (bus_req),
        .bus_grant (grant_en),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    assign bus_rdata = mem[bus_addr[9:0]];

    always @(posedge clk) begin
        if (bus_we) mem[bus_addr[9:0]] <= bus_wdata;
    end

    always @(negedge clk) begin
        int gap;
        cyc++;
        if (bus_rd) begin
            if (rd_n < 16) rd_log[rd_n] = bus_addr;
            if (rd_n > 0 && mon_bw >= 0) begin
                gap = cyc - last_t;
                case (mon_bw)
                    0: if (gap != 8) gap_bad++;
                    1: if (gap != 4) gap_bad++;
                    3: if (gap != 2) gap_bad++;
                    default: begin
                        if (gap != 2 && gap != 4) gap_bad++;
                        if (rd_n >= 3 && gap + g1 + g2 != 8) gap_bad++;
                    end
                endcase
                g2 = g1;
                g1 = gap;
            end
            last_t = cyc;
            rd_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 6'(a);
        reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output int d);
        @(negedge clk);
        reg_addr = 6'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 1024; i++) begin
            orig[i] = 8'(i * 13 + seed * 29 + 1);
            mem[i]  = orig[i];
            expm[i] = orig[i];
        end
    endtask

    task automatic mon_clear(input int bw);
        rd_n = 0;
        gap_bad = 0;
        g1 = 0;
        g2 = 0;
        mon_bw = bw;
    endtask

    task automatic wait_done(input int ch);
        int d;
        d = 0;
        for (int t = 0; t < 4000 && d == 0; t++) rd_reg(ch * 8 + 6, d);
    endtask

    task automatic setup_ch(input int ch, input int src, input int dst, input int cnt, input int ctrl);
        wr_reg(ch * 8 + 0, src & 255);
        wr_reg(ch * 8 + 1, (src >> 8) & 255);
        wr_reg(ch * 8 + 2, dst & 255);
        wr_reg(ch * 8 + 3, (dst >> 8) & 255);
        wr_reg(ch * 8 + 4, cnt);
        wr_reg(ch * 8 + 5, ctrl);
    endtask

    task automatic run_vec(input int v);
        vec_t vv;
        int n, mism, d, sa, da;
        vv = VECS[v];
        n = (vv.cnt == 8'd0) ? 256 : int'(vv.cnt);
        fill(v);
        wr_reg(56, 4 | int'(vv.bw));
        setup_ch(0, int'(vv.src), int'(vv.dst), int'(vv.cnt), int'(vv.ctrl));
        mon_clear(int'(vv.bw));
        dma_req[0] = 1'b1;
        wait_done(0);
        repeat (20) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            sa = (int'(vv.src) + (vv.ctrl[1] ? k : 0)) & 1023;
            da = (int'(vv.dst) + (vv.ctrl[2] ? k : 0)) & 1023;
            expm[da] = orig[sa];
        end
        mism = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) mism++;
        chk(mism == 0, $sformatf("R1 R2 vec %0d dest contents mismatches", v), mism, 0);
        chk(rd_n == n, $sformatf("R3 R4 vec %0d read cycles", v), rd_n, n);
        chk(gap_bad == 0, $sformatf("R7 vec %0d read spacing errors", v), gap_bad, 0);
        rd_reg(4, d);
        chk(d == 0, $sformatf("R3 vec %0d final count", v), d, 0);
        rd_reg(5, d);
        chk(d == int'(vv.ctrl & 4'hE), $sformatf("R4 vec %0d enable cleared", v), d, int'(vv.ctrl & 4'hE));
        rd_reg(6, d);
        chk(d == 1, $sformatf("R4 vec %0d done flag", v), d, 1);
        chk(irq == vv.ctrl[3], $sformatf("R5 vec %0d irq", v), int'(irq), int'(vv.ctrl[3]));
        dma_req[0] = 1'b0;
        mon_bw = -1;
        wr_reg(6, 1);
        rd_reg(6, d);
        chk(d == 0, $sformatf("R4 vec %0d done cleared", v), d, 0);
        chk(irq == 1'b0, $sformatf("R5 vec %0d irq after clear", v), int'(irq), 0);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d;
        fill(99);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        for (int o = 0; o < 7; o++) begin
            rd_reg(o, d);
            chk(d == 0, $sformatf("R10 reg offset %0d after reset", o), d, 0);
        end
        rd_reg(56, d);
        chk(d == 0, "R10 global after reset", d, 0);
        chk(irq == 0 && bus_req == 0 && bus_rd == 0 && bus_we == 0,
            "R10 bus and irq idle", int'({irq, bus_req, bus_rd, bus_we}), 0);

        // R11: register map readback on channel 2
        wr_reg(16, 8'hA5);
        wr_reg(17, 8'h3C);
        rd_reg(16, d);
        chk(d == 8'hA5, "R11 ch2 source low", d, 8'hA5);
        rd_reg(17, d);
        chk(d == 8'h3C, "R11 ch2 source high", d, 8'h3C);
        rd_reg(0, d);
        chk(d == 0, "R11 ch0 untouched by ch2 write", d, 0);

        // table-driven transfers on channel 0
        for (int v = 0; v < 8; v++) run_vec(v);

        // R6: fixed priority
        fill(11);
        wr_reg(56, 7);
        setup_ch(0, 16'h0040, 16'h0300, 3, 7);
        setup_ch(1, 16'h0080, 16'h0340, 2, 7);
        mon_clear(-1);
        dma_req = 3'b011;
        wait_done(1);
        repeat (10) @(negedge clk);
        chk(rd_log[0] == 16'h0040, "R6 first read from ch0", int'(rd_log[0]), 16'h0040);
        chk(rd_log[2] == 16'h0042, "R6 ch0 block completes first", int'(rd_log[2]), 16'h0042);
        chk(rd_log[3] == 16'h0080, "R6 ch1 follows ch0", int'(rd_log[3]), 16'h0080);
        chk(rd_n == 5, "R6 total reads", rd_n, 5);
        dma_req = '0;
        wr_reg(6, 1);
        wr_reg(14, 1);

        // R8: wait gating
        wr_reg(56, 3);
        wait_mode = 1'b1;
        setup_ch(0, 16'h0010, 16'h0380, 2, 7);
        mon_clear(-1);
        dma_req[0] = 1'b1;
        repeat (40) @(negedge clk);
        chk(rd_n == 0, "R8 no reads during wait", rd_n, 0);
        rd_reg(4, d);
        chk(d == 2, "R8 count held during wait", d, 2);
        wr_reg(56, 7);
        wait_done(0);
        repeat (5) @(negedge clk);
        chk(rd_n == 2, "R8 runs in wait when allowed", rd_n, 2);
        dma_req = '0;
        wait_mode = 1'b0;
        wr_reg(6, 1);

        // R9: grant gating
        grant_en = 1'b0;
        setup_ch(0, 16'h0010, 16'h0390, 2, 7);
        mon_clear(-1);
        dma_req[0] = 1'b1;
        repeat (30) @(negedge clk);
        chk(rd_n == 0, "R9 no reads without grant", rd_n, 0);
        chk(bus_req == 1'b1, "R9 bus_req raised", int'(bus_req), 1);
        grant_en = 1'b1;
        wait_done(0);
        repeat (5) @(negedge clk);
        chk(rd_n == 2, "R9 reads after grant", rd_n, 2);
        chk(bus_req == 1'b0, "R9 bus_req drops after block", int'(bus_req), 0);
        dma_req = '0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule